// File: doc/BRIEF.md
# Calibration and Power-Down Sequencer

This block is the mode controller that sits next to a self-calibrating pipelined conversion core. It runs on the sample clock. It watches a level-sensitive calibration request, a power-down request and an active-low output enable. From these it drives the core's calibrate-mode and power-down strobes, a ready flag for the system, and the enable for the tri-state drivers of the data outputs.

A request is accepted only after it has stayed high for a minimum number of consecutive clocks. The ready flag drops on the clock that completes that width. A calibration starts when the accepted request line goes low again and then runs for a fixed number of clocks. A power-down holds the core down for as long as its line stays high. When the line goes low, a fixed-length exit period follows before ready comes back. Each mode blocks the other one, and a blocked request is dropped rather than held over. After reset the block starts a calibration on its own. The block has no streaming data path, so every pin is a plain level signal.

Top module: `calpd_sequencer`

## Requirements
- R1: A request line that is high for fewer than QUAL_W consecutive clock samples has no effect: ready stays high and neither strobe asserts.
- R2: A qualified calibration request does not start the calibration while its line is still high. `core_cal` rises on the first clock edge that samples the line low.
- R3: `ready` goes low on the clock edge that samples a request high for the QUAL_W-th consecutive time (QUAL_W clocks after the line rises). It stays low until the resulting mode has finished.
- R4: A calibration keeps `core_cal` high for exactly CYC_LEN clock cycles. `ready` goes high on the edge that ends it.
- R5: While power-down is active (held or exiting), a calibration request has no effect on the outputs, whatever its width.
- R6: While a calibration is armed or running, a power-down request has no effect on the outputs, whatever its width.
- R7: After a qualified power-down request, `core_pd` stays high until an edge samples the line low. Then CYC_LEN clock cycles pass with `ready` low and both strobes low, and `ready` rises at the end of that period.
- R8: During reset and for CYC_LEN cycles after it is released, `core_cal` is high and `ready` is low. After that, `ready` is high.
- R9: `data_oe` is high (outputs driven) exactly when `oe_n` is low, in every mode, without a clock delay.
- R10: A request that is blocked is dropped. If its line is still high when the blocking mode ends, the block needs QUAL_W fresh high samples in the ready state before it accepts the request.
- R11: If both requests complete their width on the same edge, calibration is taken and the power-down request is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock |
| rst_n | input | 1 | Asynchronous reset, active low; release starts a calibration |
| cal_req | input | 1 | Calibration request, level sensitive, active high |
| pd_req | input | 1 | Power-down request, level sensitive, active high |
| oe_n | input | 1 | Output enable for data drivers, active low |
| ready | output | 1 | High when the core is converting normally |
| core_cal | output | 1 | Puts the conversion core into calibrate mode |
| core_pd | output | 1 | Puts the conversion core into power-down |
| data_oe | output | 1 | Enable for the data output tri-state drivers |

## Verification
The bench builds the block with CYC_LEN set to 40 and QUAL_W kept at 3. The short period brings the whole calibration length, the power-down exit period and the return to ready into each scenario. Within a few hundred cycles the bench can then reach both edges of every period exactly, along with a request still held high at the moment a blocking mode ends. With the default width kept, the short-pulse, exact-width and ready-drop cycles are checked at the value the block uses in service.

// File: rtl/calpd_pkg.sv
package calpd_pkg;

  typedef enum logic [2:0] {
    ST_IDLE    = 3'd0,
    ST_CAL_ARM = 3'd1,
    ST_CAL_RUN = 3'd2,
    ST_PD_HOLD = 3'd3,
    ST_PD_EXIT = 3'd4
  } seq_state_e;

endpackage

// File: rtl/calpd_req_qual.sv
// Counts consecutive high samples of a request while enabled; flags the
// sample that completes the minimum width.
module calpd_req_qual #(
  parameter int QUAL_W = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic en,
  input  logic req,
  output logic hit
);
  localparam int QW = (QUAL_W > 2) ? $clog2(QUAL_W) : 1;
  localparam logic [QW-1:0] LAST = QW'(QUAL_W - 1);

  logic [QW-1:0] cnt;

  assign hit = en && req && (cnt == LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt <= '0;
    end else if (!en || !req) begin
      cnt <= '0;
    end else if (cnt != LAST) begin
      cnt <= cnt + 1'b1;
    end
  end
endmodule

// File: rtl/calpd_timer.sv
// Down counter for the fixed calibration and power-down exit periods.
// Comes out of reset loaded, so the reset calibration needs no load pulse.
module calpd_timer #(
  parameter int CYC_LEN = 4000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic load,
  input  logic run,
  output logic done
);
  localparam int CNT_W = (CYC_LEN > 2) ? $clog2(CYC_LEN) : 1;
  localparam logic [CNT_W-1:0] START = CNT_W'(CYC_LEN - 1);

  logic [CNT_W-1:0] cnt;

  assign done = (cnt == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt <= START;
    end else if (load) begin
      cnt <= START;
    end else if (run && !done) begin
      cnt <= cnt - 1'b1;
    end
  end
endmodule

// File: rtl/calpd_fsm.sv
module calpd_fsm
  import calpd_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cal_hit,
  input  logic       pd_hit,
  input  logic       cal_req,
  input  logic       pd_req,
  input  logic       tmr_done,
  output seq_state_e state,
  output logic       tmr_load,
  output logic       tmr_run
);
  seq_state_e state_nx;

  always_comb begin
    state_nx = state;
    tmr_load = 1'b0;
    unique case (state)
      ST_IDLE: begin
        // calibration wins a tie; the other request is simply dropped
        if (cal_hit)     state_nx = ST_CAL_ARM;
        else if (pd_hit) state_nx = ST_PD_HOLD;
      end
      ST_CAL_ARM: begin
        if (!cal_req) begin
          state_nx = ST_CAL_RUN;
          tmr_load = 1'b1;
        end
      end
      ST_CAL_RUN: begin
        if (tmr_done) state_nx = ST_IDLE;
      end
      ST_PD_HOLD: begin
        if (!pd_req) begin
          state_nx = ST_PD_EXIT;
          tmr_load = 1'b1;
        end
      end
      ST_PD_EXIT: begin
        if (tmr_done) state_nx = ST_IDLE;
      end
      default: state_nx = ST_IDLE;
    endcase
  end

  assign tmr_run = (state == ST_CAL_RUN) || (state == ST_PD_EXIT);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state <= ST_CAL_RUN;
    else        state <= state_nx;
  end
endmodule

// File: rtl/calpd_sequencer.sv
module calpd_sequencer
  import calpd_pkg::*;
#(
  parameter int CYC_LEN = 4000,
  parameter int QUAL_W  = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic cal_req,
  input  logic pd_req,
  input  logic oe_n,
  output logic ready,
  output logic core_cal,
  output logic core_pd,
  output logic data_oe
);
  seq_state_e state;
  logic       qual_en;
  logic       cal_hit;
  logic       pd_hit;
  logic       tmr_load;
  logic       tmr_run;
  logic       tmr_done;

  // widths are only counted in the ready state, so blocked requests are lost
  assign qual_en = (state == ST_IDLE);

  calpd_req_qual #(.QUAL_W(QUAL_W)) i_cal_qual (
    .clk(clk), .rst_n(rst_n), .en(qual_en), .req(cal_req), .hit(cal_hit)
  );

  calpd_req_qual #(.QUAL_W(QUAL_W)) i_pd_qual (
    .clk(clk), .rst_n(rst_n), .en(qual_en), .req(pd_req), .hit(pd_hit)
  );

  calpd_timer #(.CYC_LEN(CYC_LEN)) i_timer (
    .clk(clk), .rst_n(rst_n), .load(tmr_load), .run(tmr_run), .done(tmr_done)
  );

  calpd_fsm i_fsm (
    .clk(clk), .rst_n(rst_n),
    .cal_hit(cal_hit), .pd_hit(pd_hit),
    .cal_req(cal_req), .pd_req(pd_req),
    .tmr_done(tmr_done),
    .state(state), .tmr_load(tmr_load), .tmr_run(tmr_run)
  );

  assign ready    = (state == ST_IDLE);
  assign core_cal = (state == ST_CAL_RUN);
  assign core_pd  = (state == ST_PD_HOLD);
  assign data_oe  = ~oe_n;
endmodule

// File: rtl/calpd_sequencer_chk.sv
module calpd_sequencer_chk #(
  parameter int CYC_LEN = 4000,
  parameter int QUAL_W  = 3
) (
  input logic clk,
  input logic rst_n,
  input logic cal_req,
  input logic pd_req,
  input logic ready,
  input logic core_cal,
  input logic core_pd
);
  logic [7:0]  cal_run_len;
  logic [7:0]  pd_run_len;
  logic [31:0] cal_len;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cal_run_len <= '0;
      pd_run_len  <= '0;
      cal_len     <= '0;
    end else begin
      cal_run_len <= !cal_req ? 8'd0 : (cal_run_len == 8'hff) ? cal_run_len : cal_run_len + 8'd1;
      pd_run_len  <= !pd_req  ? 8'd0 : (pd_run_len  == 8'hff) ? pd_run_len  : pd_run_len  + 8'd1;
      cal_len     <= !core_cal ? 32'd0 : cal_len + 32'd1;
    end
  end

  AST_READY_DROP_QUAL: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ready) |-> (32'(cal_run_len) >= 32'(QUAL_W) || 32'(pd_run_len) >= 32'(QUAL_W))); // R3

  AST_CAL_ON_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(core_cal) |-> !$past(cal_req)); // R2

  AST_CAL_LENGTH: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(core_cal) |-> (cal_len == 32'(CYC_LEN))); // R4

  AST_PD_FROM_READY: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(core_pd) |-> $past(ready)); // R6

  AST_CAL_NOT_FROM_PD: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(core_cal) |-> !$past(core_pd)); // R5
endmodule

bind calpd_sequencer calpd_sequencer_chk #(.CYC_LEN(CYC_LEN), .QUAL_W(QUAL_W)) i_chk (
  .clk(clk), .rst_n(rst_n), .cal_req(cal_req), .pd_req(pd_req),
  .ready(ready), .core_cal(core_cal), .core_pd(core_pd)
);

// File: tb/test_calpd_sequencer.sv
module test_calpd_sequencer;
  localparam int N = 40;
  localparam int W = 3;
  // {ready, core_cal, core_pd, data_oe}
  localparam logic [3:0] IDLE_V = 4'b1001;
  localparam logic [3:0] RUN_V  = 4'b0101;
  localparam logic [3:0] PDH_V  = 4'b0011;
  localparam logic [3:0] WAIT_V = 4'b0001;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cal_req = 1'b0;
  logic pd_req = 1'b0;
  logic oe_n = 1'b0;
  logic ready, core_cal, core_pd, data_oe;

  int cyc = 0;
  int errors = 0;
  int checks = 0;

  typedef struct {
    int         cyc;
    logic [3:0] v;
    string      tag;
  } exp_t;
  exp_t q[$];
  exp_t e;

  always #10 clk = ~clk;

  calpd_sequencer #(.CYC_LEN(N), .QUAL_W(W)) i_calpd_sequencer (
    .clk(clk), .rst_n(rst_n), .cal_req(cal_req), .pd_req(pd_req), .oe_n(oe_n),
    .ready(ready), .core_cal(core_cal), .core_pd(core_pd), .data_oe(data_oe)
  );

  always @(posedge clk) begin
    if (!rst_n) cyc <= 0;
    else        cyc <= cyc + 1;
  end

  // monitor: compare scoreboard entries due in this cycle
  always @(negedge clk) begin
    while (q.size() > 0 && q[0].cyc <= cyc) begin
      e = q.pop_front();
      checks++;
      if (e.cyc != cyc || {ready, core_cal, core_pd, data_oe} != e.v) begin
        errors++;
        $display("FAIL %s cycle %0d: got %b expected %b (due %0d)",
                 e.tag, cyc, {ready, core_cal, core_pd, data_oe}, e.v, e.cyc);
      end
    end
  end

  task automatic want(input int c, input logic [3:0] v, input string tag);
    exp_t x;
    x.cyc = c; x.v = v; x.tag = tag;
    q.push_back(x);
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
    #1;
  endtask

  task automatic finish_run();
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog: got hang expected completion");
    finish_run();
  end

  initial begin
    int c;
    // R8: reset state and automatic calibration
    want(0, RUN_V, "R8");
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #1;
    want(N - 1, RUN_V, "R8");
    want(N, IDLE_V, "R8_R4");
    tick(N + 2);

    // R1: two-sample pulse ignored
    c = cyc;
    want(c + 2, IDLE_V, "R1");
    want(c + 3, IDLE_V, "R1");
    want(c + 6, IDLE_V, "R1");
    cal_req = 1'b1; tick(2); cal_req = 1'b0; tick(8);

    // R2/R3/R4: held request, start on release
    c = cyc;
    want(c + 2, IDLE_V, "R3");
    want(c + 3, WAIT_V, "R3");
    want(c + 6, WAIT_V, "R2");
    want(c + 7, RUN_V, "R2");
    want(c + 6 + N, RUN_V, "R4");
    want(c + 7 + N, IDLE_V, "R4");
    cal_req = 1'b1; tick(6); cal_req = 1'b0; tick(N + 4);

    // R7/R5: power-down with calibration request during hold
    c = cyc;
    want(c + 2, IDLE_V, "R7");
    want(c + 3, PDH_V, "R7");
    want(c + 10, PDH_V, "R5");
    want(c + 11, WAIT_V, "R7");
    want(c + 10 + N, WAIT_V, "R7");
    want(c + 11 + N, IDLE_V, "R7");
    want(c + 14 + N, IDLE_V, "R5");
    pd_req = 1'b1; tick(4);
    cal_req = 1'b1; tick(4);
    cal_req = 1'b0; tick(2);
    pd_req = 1'b0; tick(N + 6);

    // R6: power-down request during calibration
    c = cyc;
    want(c + 3, WAIT_V, "R3");
    want(c + 4, RUN_V, "R2");
    want(c + 10, RUN_V, "R6");
    want(c + 3 + N, RUN_V, "R4");
    want(c + 4 + N, IDLE_V, "R4");
    want(c + 7 + N, IDLE_V, "R6");
    cal_req = 1'b1; tick(3);
    cal_req = 1'b0; tick(2);
    pd_req = 1'b1; tick(10);
    pd_req = 1'b0; tick(N);

    // R10: calibration request held across the end of power-down
    c = cyc;
    want(c + 3, PDH_V, "R7");
    want(c + 4, WAIT_V, "R7");
    want(c + 3 + N, WAIT_V, "R10");
    want(c + 4 + N, IDLE_V, "R10");
    want(c + 6 + N, IDLE_V, "R10");
    want(c + 7 + N, WAIT_V, "R10");
    want(c + 8 + N, RUN_V, "R10");
    want(c + 7 + 2 * N, RUN_V, "R4");
    want(c + 8 + 2 * N, IDLE_V, "R4");
    pd_req = 1'b1; tick(3);
    pd_req = 1'b0; tick(2);
    cal_req = 1'b1; tick(N + 2);
    cal_req = 1'b0; tick(N + 4);

    // R11: both requests qualify together
    c = cyc;
    want(c + 3, WAIT_V, "R11");
    want(c + 4, RUN_V, "R11");
    want(c + 4 + N, IDLE_V, "R11");
    want(c + 7 + N, IDLE_V, "R11");
    cal_req = 1'b1; pd_req = 1'b1; tick(3);
    cal_req = 1'b0; pd_req = 1'b0; tick(N + 8);

    // R9: output enable in ready state and during calibration
    c = cyc;
    want(c + 1, 4'b1000, "R9");
    want(c + 3, IDLE_V, "R9");
    want(c + 10, 4'b0100, "R9");
    want(c + 8 + N, IDLE_V, "R9");
    oe_n = 1'b1; tick(2);
    oe_n = 1'b0; tick(2);
    cal_req = 1'b1; tick(3);
    cal_req = 1'b0; tick(2);
    oe_n = 1'b1; tick(2);
    oe_n = 1'b0; tick(N + 4);

    tick(2);
    if (q.size() != 0) begin
      errors++; checks++;
      $display("FAIL scoreboard: got %0d pending expected 0", q.size());
    end
    finish_run();
  end
endmodule